// File: doc/BRIEF.md
# Peripheral Power and Clock Gating Controller

This block governs a single peripheral. It decides, every cycle, whether the peripheral receives supply, whether its clock runs, and whether it is held in reset. It bases the decision on three inputs. The first is the operating mode of the device: run, sleep or deep-sleep. The second is a clock-gate enable bit for each of those modes. The third is a software-owned power-keep bit. Power and clock are decided separately. A gate bit that is set forces full operation. With the gate clear, the power-keep bit alone chooses between two states: a retention state, where supply stays on but the clock is stopped, and a full shutdown, where state is lost.

The power-keep bit sits in a 32-bit control word with a write strobe. Only bit 0 of that word holds a value. The whole word can be read back at any time. When the peripheral comes out of shutdown, it gets a reset pulse of fixed length. A settle counter then raises a ready flag after supply has been stable for a set time. Software polls the ready flag before it touches the peripheral.

The controller is a four-state machine:
- **OFF**: unpowered and unclocked.
- **RESET**: powered, clock stopped, reset held.
- **RETAIN**: powered, clock stopped.
- **ACTIVE**: powered and clocked.

The transitions are:
- **wake**: OFF to RESET, when power is wanted.
- **release_active**: RESET to ACTIVE, when the pulse ends and the gate is set.
- **release_retain**: RESET to RETAIN, when the pulse ends and the gate is clear.
- **abort**: RESET to OFF, when power is no longer wanted.
- **gate_on**: RETAIN to ACTIVE.
- **gate_off**: ACTIVE to RETAIN.
- **drop**: RETAIN or ACTIVE to OFF, when neither the gate nor the power-keep bit is set.

Top module: `pgate_ctrl`

## Requirements
- R1: When the gate bit chosen by the current mode is 1, the block settles in ACTIVE, with pwr_en=1 and clk_en=1, whatever the power-keep bit holds. clk_en is never 1 while pwr_en is 0.
- R2: When the selected gate bit is 0 and the power-keep bit is 0, the block enters OFF on the next clock edge, with pwr_en=0, clk_en=0 and periph_rst=0. This includes an abort from RESET.
- R3: When the selected gate bit is 0 and the power-keep bit is 1, the block holds pwr_en=1 and clk_en=0.
- R4: Leaving OFF, for either cause, raises periph_rst for exactly RST_CYCLES cycles (default 4). The causes are a mode or gate change that selects a set gate bit, or a power-keep change from 0 to 1. clk_en stays 0 during the pulse. If the gate is set, clk_en rises in the cycle after the pulse ends.
- R5: A mode, gate or register change that moves between powered states (RETAIN and ACTIVE) never raises periph_rst.
- R6: After reset, the power-keep bit is 0 and pwr_en, clk_en, periph_rst and ready are all 0.
- R7: A write with wr_en=1 stores wr_data[0] as the power-keep bit, and the stored value is visible from the next cycle. rd_data[0] returns the bit. rd_data[31:1] always reads 0, whatever was written.
- R8: ready is 1 only after pwr_en has been 1 for SETTLE_CYCLES consecutive cycles (default 16). It drops to 0 in the same cycle that pwr_en drops to 0.
- R9: The op_mode encoding is as follows. 2'b00 selects gate_run. 2'b01 selects gate_sleep. 2'b10 selects gate_deep. 2'b11 is treated as run and selects gate_run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 2 | Device operating mode (R9 encoding) |
| gate_run | input | 1 | Clock-gate enable used in run mode |
| gate_sleep | input | 1 | Clock-gate enable used in sleep mode |
| gate_deep | input | 1 | Clock-gate enable used in deep-sleep mode |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data; only bit 0 is kept |
| rd_data | output | 32 | Control word readback; bit 0 is the power-keep bit |
| pwr_en | output | 1 | Peripheral supply enable |
| clk_en | output | 1 | Peripheral clock enable |
| periph_rst | output | 1 | Peripheral reset, active high |
| ready | output | 1 | Supply settled; peripheral may be accessed |

## Verification
The hardest case to reach is the abort out of RESET. Reaching it needs the power request to vanish while the pulse is still running, which requires a gate or mode change that lands inside a window of a few cycles. A second hard case is a power-keep write that arrives within that same window. The stimulus places these events on exact cycle offsets after a wake. It also produces short power blips, shorter than the settle time, to check that ready never rises early. A long pseudo-random phase then changes mode, gates and writes every few cycles, and a behavioural reference model is compared against the design on every clock.

// File: rtl/pgate_pkg.sv
package pgate_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_RESET  = 2'd1,
        ST_RETAIN = 2'd2,
        ST_ACTIVE = 2'd3
    } pg_state_e;

    localparam logic [1:0] MODE_RUN   = 2'b00;
    localparam logic [1:0] MODE_SLEEP = 2'b01;
    localparam logic [1:0] MODE_DEEP  = 2'b10;

endpackage

// File: rtl/pgate_mode_sel.sv
module pgate_mode_sel
    import pgate_pkg::*;
(
    input  logic [1:0] op_mode,
    input  logic       gate_run,
    input  logic       gate_sleep,
    input  logic       gate_deep,
    output logic       gate_sel
);

    always_comb begin
        unique case (op_mode)
            MODE_SLEEP: gate_sel = gate_sleep;
            MODE_DEEP:  gate_sel = gate_deep;
            default:    gate_sel = gate_run;   // run and the spare code
        endcase
    end

endmodule

// File: rtl/pgate_fsm.sv
module pgate_fsm
    import pgate_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_sel,
    input  logic keep_pwr,
    output logic pwr_en,
    output logic clk_en,
    output logic periph_rst
);

    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(RST_CYCLES - 1);

    pg_state_e state_q, state_d;
    logic [CW-1:0] rcnt_q, rcnt_d;
    logic want_pwr;

    assign want_pwr = gate_sel | keep_pwr;

    always_comb begin
        state_d = state_q;
        rcnt_d  = rcnt_q;
        unique case (state_q)
            ST_OFF: begin
                if (want_pwr) begin          // wake
                    state_d = ST_RESET;
                    rcnt_d  = '0;
                end
            end
            ST_RESET: begin
                if (!want_pwr) begin
                    state_d = ST_OFF;        // abort
                end else if (rcnt_q == CNT_LAST) begin
                    state_d = gate_sel ? ST_ACTIVE : ST_RETAIN;
                end else begin
                    rcnt_d = rcnt_q + 1'b1;
                end
            end
            ST_RETAIN: begin
                if (!want_pwr)     state_d = ST_OFF;     // drop
                else if (gate_sel) state_d = ST_ACTIVE;  // gate_on
            end
            ST_ACTIVE: begin
                if (!want_pwr)      state_d = ST_OFF;     // drop
                else if (!gate_sel) state_d = ST_RETAIN;  // gate_off
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            rcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            rcnt_q  <= rcnt_d;
        end
    end

    always_comb begin
        pwr_en     = 1'b0;
        clk_en     = 1'b0;
        periph_rst = 1'b0;
        unique case (state_q)
            ST_OFF:    ;
            ST_RESET:  begin pwr_en = 1'b1; periph_rst = 1'b1; end
            ST_RETAIN: pwr_en = 1'b1;
            ST_ACTIVE: begin pwr_en = 1'b1; clk_en = 1'b1; end
            default:   ;
        endcase
    end

endmodule

// File: rtl/pgate_settle.sv
module pgate_settle #(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    output logic ready
);

    localparam int SW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [SW-1:0] SET_MAX = SW'(SETTLE_CYCLES);

    logic [SW-1:0] scnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 scnt_q <= '0;
        else if (!pwr_en)           scnt_q <= '0;
        else if (scnt_q != SET_MAX) scnt_q <= scnt_q + 1'b1;
    end

    assign ready = pwr_en && (scnt_q == SET_MAX);

endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl #(
    parameter int REG_W         = 32,
    parameter int RST_CYCLES    = 4,
    parameter int SETTLE_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op_mode,
    input  logic             gate_run,
    input  logic             gate_sleep,
    input  logic             gate_deep,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             pwr_en,
    output logic             clk_en,
    output logic             periph_rst,
    output logic             ready
);

    logic keep_q;
    logic gate_sel;
    logic unused_wr_hi;

    assign unused_wr_hi = ^wr_data[REG_W-1:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     keep_q <= 1'b0;
        else if (wr_en) keep_q <= wr_data[0];
    end

    assign rd_data = {{(REG_W-1){1'b0}}, keep_q};

    pgate_mode_sel u_sel (
        .op_mode    (op_mode),
        .gate_run   (gate_run),
        .gate_sleep (gate_sleep),
        .gate_deep  (gate_deep),
        .gate_sel   (gate_sel)
    );

    pgate_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_sel   (gate_sel),
        .keep_pwr   (keep_q),
        .pwr_en     (pwr_en),
        .clk_en     (clk_en),
        .periph_rst (periph_rst)
    );

    pgate_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_en (pwr_en),
        .ready  (ready)
    );

endmodule

// File: rtl/pgate_ctrl_chk.sv
module pgate_ctrl_chk #(
    parameter int REG_W      = 32,
    parameter int RST_CYCLES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       op_mode,
    input logic             gate_run,
    input logic             gate_sleep,
    input logic             gate_deep,
    input logic [REG_W-1:0] rd_data,
    input logic             pwr_en,
    input logic             clk_en,
    input logic             periph_rst,
    input logic             ready
);

    logic        m_gate;
    logic [15:0] len_q;

    assign m_gate = (op_mode == 2'b01) ? gate_sleep :
                    (op_mode == 2'b10) ? gate_deep  : gate_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          len_q <= '0;
        else if (periph_rst) len_q <= (len_q == 16'hFFFF) ? len_q : len_q + 1'b1;
        else                 len_q <= '0;
    end

    assert_clk_needs_pwr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> pwr_en);

    assert_idle_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_gate && !rd_data[0]) |=> !pwr_en);

    assert_no_clk_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        periph_rst |-> !clk_en);

    assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(periph_rst) && pwr_en) |-> (len_q == 16'(RST_CYCLES)));

    assert_no_reset_when_powered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_en) && $past(!periph_rst)) |-> !periph_rst);

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:1] == '0);

    assert_ready_needs_pwr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> pwr_en);

    assert_not_ready_on_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> !ready);

endmodule

bind pgate_ctrl pgate_ctrl_chk #(.REG_W(REG_W), .RST_CYCLES(RST_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_mode    (op_mode),
    .gate_run   (gate_run),
    .gate_sleep (gate_sleep),
    .gate_deep  (gate_deep),
    .rd_data    (rd_data),
    .pwr_en     (pwr_en),
    .clk_en     (clk_en),
    .periph_rst (periph_rst),
    .ready      (ready)
);

// File: tb/test_pgate_ctrl.sv
module test_pgate_ctrl;

    localparam int RSTC = 4;
    localparam int SETC = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_mode = 2'b00;
    logic        gate_run = 1'b0, gate_sleep = 1'b0, gate_deep = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwr_en, clk_en, periph_rst, ready;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural model: 0 off, 1 reset pulse, 2 retain, 3 active
    int m_st   = 0;
    int m_rc   = 0;
    int m_sc   = 0;
    bit m_keep = 0;

    always #2 clk = ~clk;   // 250 MHz

    pgate_ctrl #(.RST_CYCLES(RSTC), .SETTLE_CYCLES(SETC)) i_pgate_ctrl (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode),
        .gate_run(gate_run), .gate_sleep(gate_sleep), .gate_deep(gate_deep),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .pwr_en(pwr_en), .clk_en(clk_en), .periph_rst(periph_rst), .ready(ready)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_rc = 0; m_sc = 0; m_keep = 0;
        end else begin
            bit sel, want;
            int old_st;
            // R9: 01 sleep, 10 deep, 00 and 11 run
            sel = (op_mode == 2'b01) ? gate_sleep :
                  (op_mode == 2'b10) ? gate_deep : gate_run;
            want = sel | m_keep;
            old_st = m_st;
            if (m_st == 0) begin
                if (want) begin m_st = 1; m_rc = 0; end
            end else if (m_st == 1) begin
                if (!want) m_st = 0;
                else if (m_rc == RSTC - 1) m_st = sel ? 3 : 2;
                else m_rc++;
            end else begin
                if (!want) m_st = 0;
                else m_st = sel ? 3 : 2;
            end
            if (old_st == 0) m_sc = 0;
            else if (m_sc < SETC) m_sc++;
            if (wr_en) m_keep = wr_data[0];
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        chk({31'b0, pwr_en},     {31'b0, m_st != 0},   "R1 R2 R3 pwr_en");
        chk({31'b0, clk_en},     {31'b0, m_st == 3},   "R1 R3 R4 clk_en");
        chk({31'b0, periph_rst}, {31'b0, m_st == 1},   "R4 R5 periph_rst");
        chk({31'b0, ready},      {31'b0, (m_st != 0) && (m_sc == SETC)}, "R8 ready");
        chk(rd_data,             {31'b0, m_keep},      "R7 rd_data");
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin : watchdog
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        step(3);
        // R6: reset state
        chk({28'b0, pwr_en, clk_en, periph_rst, ready}, 32'h0, "R6 outputs in reset");
        chk(rd_data, 32'h0, "R6 keep bit in reset");
        @(negedge clk) rst_n = 1'b1;
        step(5);                                   // R2: idle off
        wr(32'hFFFF_FFFF);                         // R7 only bit 0, R4 wake, R3 retain
        step(SETC + 8);                            // R8 settle
        gate_run = 1'b1; step(6);                  // R5 gate_on no reset
        gate_run = 1'b0; step(4);                  // R5 gate_off
        wr(32'h0000_0002); step(4);                // R7 bit1 ignored -> drop, R8 ready falls
        gate_sleep = 1'b1; op_mode = 2'b01; step(10); // R9 sleep selects its gate, R4 pulse
        op_mode = 2'b10; step(4);                  // R9 deep gate 0 -> off (R2)
        op_mode = 2'b11; gate_run = 1'b1; step(8); // R9 spare code acts as run (R1)
        chk({31'b0, clk_en}, 32'h1, "R9 code 11 as run");
        op_mode = 2'b01; gate_sleep = 1'b0; step(3);
        // abort from RESET two cycles into the pulse (R2)
        op_mode = 2'b00; step(2); gate_run = 1'b0; step(3);
        // keep write during reset pulse: ends in retain (R3, R4)
        gate_run = 1'b1; step(1); wr(32'h1); gate_run = 1'b0; step(8);
        wr(32'h0); step(2);
        // short blips below settle time (R8)
        for (int b = 0; b < 4; b++) begin
            gate_deep = 1'b1; op_mode = 2'b10; step(6 + b);
            gate_deep = 1'b0; step(2);
        end
        // pseudo-random phase
        lfsr = 16'hACE1;
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            @(negedge clk);
            if (lfsr[2:0] == 3'd0) op_mode = lfsr[5:4];
            if (lfsr[3:1] == 3'd1) gate_run = lfsr[6];
            if (lfsr[3:1] == 3'd2) gate_sleep = lfsr[7];
            if (lfsr[3:1] == 3'd3) gate_deep = lfsr[8];
            wr_en = (lfsr[11:9] == 3'd5);
            wr_data = {lfsr, lfsr};
        end
        wr_en = 1'b0;
        step(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule